// File: doc/BRIEF.md
# Interrupt Destination Match Unit

This block sits on the receive side of a processor's interrupt controller. Every interrupt message on the shared delivery fabric carries a destination mode bit and an 8-bit destination code. This unit decides whether the message is meant for the local processor. It holds three configuration values:

- a 4-bit physical identity,
- an 8-bit logical identity,
- a 4-bit addressing-model selector.

Software writes each of these through a small register port.

A physical-mode message is compared against the physical identity. A logical-mode message is compared against the logical identity, in one of two ways:

- **Bitmap model:** each bit of the identity names one processor, and any shared set bit is a hit.
- **Grouped model:** the upper nibble names a group and the lower nibble is a member bitmap within that group. A group code of all ones reaches every group.

The accept decision is registered and appears one cycle after the message is presented. Arbitration among several accepting processors is handled elsewhere.

Top module: `ldm_unit`

## Requirements
- R1: After reset the model selector reads 0xF0000000 (bitmap model), the logical identity reads 0, the physical identity reads the parameter `RESET_PID` (default 0), and `accept` is low.
- R2: The register port is decoded by `cfg_sel` as follows:
  - 0 selects the physical identity in data bits 3:0.
  - 1 selects the logical identity in data bits 31:24.
  - 2 selects the model selector in data bits 31:28.

  A write with `cfg_we` high updates the selected field at the clock edge. `cfg_rdata` shows the selected field combinationally, and all other bits read 0.
- R3: `accept` is registered. It is high in the cycle after a cycle with `msg_valid` high and a match, and it is low after any cycle with `msg_valid` low.
- R4: In physical mode (`msg_logical`=0), a message matches when `msg_dest[3:0]` equals the physical identity. `msg_dest[7:4]` is ignored.
- R5: In physical mode, `msg_dest[3:0]`=0xF matches on every unit, whatever the physical identity.
- R6: In logical mode with a model selector of 0xF (bitmap model), a message matches exactly when `msg_dest` AND the logical identity is non-zero. A logical identity of 0 therefore never matches.
- R7: In logical mode with any model selector other than 0xF (grouped model), a message matches when two conditions both hold:
  - `msg_dest[7:4]` equals logical identity bits 7:4.
  - `msg_dest[3:0]` AND logical identity bits 3:0 is non-zero.
- R8: In grouped model, a destination group of 0xF matches any local group, provided the member bitmaps overlap.
- R9: A message presented in the same cycle as a configuration write is judged against the configuration values held before that write.
- R10: A write with `cfg_sel`=3 changes no stored value, and reads with `cfg_sel`=3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register selector (0 physical identity, 1 logical identity, 2 model selector, 3 unused) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| msg_valid | input | 1 | An interrupt message is present this cycle |
| msg_logical | input | 1 | Destination mode: 0 physical, 1 logical |
| msg_dest | input | 8 | Destination code of the message |
| accept | output | 1 | Registered decision that the message targets this unit |

## Verification
A configuration write and a message judgement can fall in the same clock cycle. The bench provokes this by driving a logical-identity write and a logical message in one cycle. It uses destinations that match only the old identity in one case and only the new identity in the other. The next-cycle `accept` must follow the old identity, and a repeated message one cycle later must follow the new one. The bench also sweeps every destination code across physical, bitmap and grouped settings, and compares each result with an expected value computed arithmetically in the bench.

// File: rtl/ldm_pkg.sv
package ldm_pkg;
  localparam int DATA_W  = 32;
  localparam int PID_W   = 4;
  localparam int LID_W   = 8;
  localparam int FMT_W   = 4;
  localparam int GRP_W   = LID_W / 2;
  localparam int LID_LSB = DATA_W - LID_W;
  localparam int FMT_LSB = DATA_W - FMT_W;

  typedef enum logic [1:0] {
    SEL_PID  = 2'd0,
    SEL_LID  = 2'd1,
    SEL_FMT  = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;

  localparam logic [FMT_W-1:0] FMT_BITMAP = '1;
endpackage

// File: rtl/ldm_rst_sync.sv
module ldm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ldm_cfg_regs.sv
module ldm_cfg_regs
  import ldm_pkg::*;
#(
  parameter logic [PID_W-1:0] RESET_PID = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic [PID_W-1:0]  pid,
  output logic [LID_W-1:0]  lid,
  output logic [FMT_W-1:0]  fmt
);
  logic [PID_W-1:0] pid_q, pid_d;
  logic [LID_W-1:0] lid_q, lid_d;
  logic [FMT_W-1:0] fmt_q, fmt_d;
  logic             pid_en, lid_en, fmt_en;
  cfg_sel_e         sel;
  logic             unused_wdata;

  assign sel          = cfg_sel_e'(cfg_sel);
  assign unused_wdata = ^cfg_wdata[LID_LSB-1:PID_W];

  // Clock enables per field
  always_comb begin
    pid_en = cfg_we && (sel == SEL_PID);
    lid_en = cfg_we && (sel == SEL_LID);
    fmt_en = cfg_we && (sel == SEL_FMT);
  end

  // Next-state
  always_comb begin
    pid_d = pid_q;
    lid_d = lid_q;
    fmt_d = fmt_q;
    if (pid_en) pid_d = cfg_wdata[PID_W-1:0];
    if (lid_en) lid_d = cfg_wdata[DATA_W-1:LID_LSB];
    if (fmt_en) fmt_d = cfg_wdata[DATA_W-1:FMT_LSB];
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pid_q <= RESET_PID;
      lid_q <= '0;
      fmt_q <= FMT_BITMAP;
    end else begin
      pid_q <= pid_d;
      lid_q <= lid_d;
      fmt_q <= fmt_d;
    end
  end

  // Read mux
  always_comb begin
    cfg_rdata = '0;
    unique case (sel)
      SEL_PID:  cfg_rdata[PID_W-1:0]        = pid_q;
      SEL_LID:  cfg_rdata[DATA_W-1:LID_LSB] = lid_q;
      SEL_FMT:  cfg_rdata[DATA_W-1:FMT_LSB] = fmt_q;
      SEL_NONE: cfg_rdata                   = '0;
    endcase
  end

  assign pid = pid_q;
  assign lid = lid_q;
  assign fmt = fmt_q;

  AST_LID_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd1) |=> (lid_q == $past(cfg_wdata[DATA_W-1:LID_LSB]))); // R2
  AST_UNUSED_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd3) |=> $stable({pid_q, lid_q, fmt_q})); // R10
endmodule

// File: rtl/ldm_match.sv
module ldm_match
  import ldm_pkg::*;
(
  input  logic             msg_logical,
  input  logic [LID_W-1:0] msg_dest,
  input  logic [PID_W-1:0] pid,
  input  logic [LID_W-1:0] lid,
  input  logic [FMT_W-1:0] fmt,
  output logic             hit
);
  logic [LID_W-1:0] overlap;
  logic             phys_hit, bitmap_hit, grp_hit;
  logic             grp_same, grp_bcast, member_hit;

  genvar b;
  generate
    for (b = 0; b < LID_W; b++) begin : g_overlap
      assign overlap[b] = msg_dest[b] & lid[b];
    end
  endgenerate

  always_comb begin
    phys_hit   = (msg_dest[PID_W-1:0] == pid) || (msg_dest[PID_W-1:0] == '1);
    bitmap_hit = |overlap;
    grp_same   = (msg_dest[LID_W-1:GRP_W] == lid[LID_W-1:GRP_W]);
    grp_bcast  = (msg_dest[LID_W-1:GRP_W] == '1);
    member_hit = |overlap[GRP_W-1:0];
    grp_hit    = (grp_same || grp_bcast) && member_hit;
    if (!msg_logical)           hit = phys_hit;
    else if (fmt == FMT_BITMAP) hit = bitmap_hit;
    else                        hit = grp_hit;
  end
endmodule

// File: rtl/ldm_unit.sv
module ldm_unit
  import ldm_pkg::*;
#(
  parameter logic [PID_W-1:0] RESET_PID = '0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        msg_valid,
  input  logic        msg_logical,
  input  logic [7:0]  msg_dest,
  output logic        accept
);
  logic             rst_sync_n;
  logic [PID_W-1:0] pid;
  logic [LID_W-1:0] lid;
  logic [FMT_W-1:0] fmt;
  logic             hit;
  logic             accept_q, accept_d;

  ldm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ldm_cfg_regs #(.RESET_PID(RESET_PID)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .pid       (pid),
    .lid       (lid),
    .fmt       (fmt)
  );

  ldm_match u_match (
    .msg_logical (msg_logical),
    .msg_dest    (msg_dest),
    .pid         (pid),
    .lid         (lid),
    .fmt         (fmt),
    .hit         (hit)
  );

  always_comb accept_d = msg_valid && hit;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) accept_q <= 1'b0;
    else             accept_q <= accept_d;
  end

  assign accept = accept_q;

  AST_IDLE_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !msg_valid |=> !accept); // R3
  AST_PHYS_BCAST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (msg_valid && !msg_logical && msg_dest[3:0] == 4'hF) |=> accept); // R5
  AST_ZERO_LID_NO_HIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (msg_valid && msg_logical && lid == '0) |=> !accept); // R6
  AST_GROUP_MISS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (msg_valid && msg_logical && fmt != 4'hF && msg_dest[7:4] != lid[7:4]
     && msg_dest[7:4] != 4'hF) |=> !accept); // R7
endmodule

// File: tb/ldm_unit_tb.sv
module ldm_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        msg_valid = 1'b0;
  logic        msg_logical = 1'b0;
  logic [7:0]  msg_dest = '0;
  logic        accept;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  ldm_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .msg_valid(msg_valid),
    .msg_logical(msg_logical), .msg_dest(msg_dest), .accept(accept)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic bit model(input bit logical, input logic [7:0] d,
                               input logic [3:0] p, input logic [7:0] l,
                               input logic [3:0] f);
    if (!logical) return (d % 16 == p) || (d % 16 == 15);
    if (f == 4'hF) return (d & l) != 0;
    return ((d / 16 == l / 16) || (d / 16 == 15)) && ((d % 16) & (l % 16)) != 0;
  endfunction

  task automatic wr(input logic [1:0] s, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [1:0] s, input logic [31:0] exp);
    @(negedge clk);
    cfg_sel = s;
    #1;
    check(req, cfg_rdata, exp);
  endtask

  task automatic send(input string req, input bit lg, input logic [7:0] d, input bit exp);
    @(negedge clk);
    msg_valid = 1'b1; msg_logical = lg; msg_dest = d;
    @(negedge clk);
    msg_valid = 1'b0;
    check(req, {31'd0, accept}, {31'd0, exp});
  endtask

  initial begin
    logic [3:0] pid_set[2] = '{4'h5, 4'hA};
    logic [7:0] flat_set[3] = '{8'h00, 8'h01, 8'hA4};
    logic [7:0] grp_set[3] = '{8'h31, 8'h5A, 8'hE6};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 accept", {31'd0, accept}, 32'd0);
    rd("R1 fmt", 2'd2, 32'hF000_0000);
    rd("R1 lid", 2'd1, 32'h0);
    rd("R1 pid", 2'd0, 32'h0);

    // R2 register port placement and reserved bits
    wr(2'd0, 32'hFFFF_FFF7);  rd("R2 pid", 2'd0, 32'h7);
    wr(2'd1, 32'hC3FF_FFFF);  rd("R2 lid", 2'd1, 32'hC300_0000);
    wr(2'd2, 32'h5FFF_FFFF);  rd("R2 fmt", 2'd2, 32'h5000_0000);

    // R10 unused selector
    wr(2'd3, 32'hFFFF_FFFF);
    rd("R10 read", 2'd3, 32'h0);
    rd("R10 pid", 2'd0, 32'h7);
    rd("R10 lid", 2'd1, 32'hC300_0000);
    rd("R10 fmt", 2'd2, 32'h5000_0000);

    // R3 no accept without valid
    @(negedge clk);
    msg_valid = 1'b0; msg_logical = 1'b0; msg_dest = 8'h07;
    @(negedge clk);
    check("R3 idle", {31'd0, accept}, 32'd0);

    // R4 R5 physical sweep
    foreach (pid_set[i]) begin
      wr(2'd0, {28'd0, pid_set[i]});
      for (int d = 0; d < 256; d++)
        send((d % 16 == 15) ? "R5 phys bcast" : "R4 phys", 1'b0, d[7:0],
             model(1'b0, d[7:0], pid_set[i], 8'h00, 4'hF));
    end

    // R6 bitmap sweep
    wr(2'd2, 32'hF000_0000);
    foreach (flat_set[i]) begin
      wr(2'd1, {flat_set[i], 24'd0});
      for (int d = 0; d < 256; d++)
        send("R6 bitmap", 1'b1, d[7:0], model(1'b1, d[7:0], 4'hA, flat_set[i], 4'hF));
    end

    // R7 R8 grouped sweep, two non-bitmap selector values
    for (int f = 0; f < 2; f++) begin
      logic [3:0] fv = (f == 0) ? 4'h0 : 4'h7;
      wr(2'd2, {fv, 28'd0});
      foreach (grp_set[i]) begin
        wr(2'd1, {grp_set[i], 24'd0});
        for (int d = 0; d < 256; d++)
          send((d / 16 == 15) ? "R8 group bcast" : "R7 group", 1'b1, d[7:0],
               model(1'b1, d[7:0], 4'hA, grp_set[i], fv));
      end
    end

    // R9 write and message in the same cycle
    wr(2'd2, 32'hF000_0000);
    wr(2'd1, 32'h0100_0000);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 32'h0200_0000;
    msg_valid = 1'b1; msg_logical = 1'b1; msg_dest = 8'h02;
    @(negedge clk);
    cfg_we = 1'b0; msg_valid = 1'b0;
    check("R9 old lid miss", {31'd0, accept}, 32'd0);
    send("R9 new lid hit", 1'b1, 8'h02, 1'b1);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 32'h0100_0000;
    msg_valid = 1'b1; msg_logical = 1'b1; msg_dest = 8'h02;
    @(negedge clk);
    cfg_we = 1'b0; msg_valid = 1'b0;
    check("R9 old lid hit", {31'd0, accept}, 32'd1);
    send("R9 new lid miss", 1'b1, 8'h02, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule